// File: doc/BRIEF.md
# Cascadable Presettable Synchronous Binary Counter

This block is one stage of a synchronous binary counter. Each rising clock edge it either clears, loads a preset value, increments or holds. It increments only when two count enables are both high. The first is a parallel enable that gates only this stage. The second is a trickle enable that also gates the terminal-count flag.

The terminal-count flag is combinational. It is high while the stage sits at its all-ones value and the trickle enable is high. Long counters are built by feeding each stage's flag into the trickle enable of the stage above, with every stage sharing the same clock. Because the flag is combinational, a lower stage wrapping and the stage above it incrementing happen on the same edge.

A modulus below the natural range is made by decoding a chosen count outside the block and driving the synchronous clear from that decode. The stage width is a parameter and defaults to 4 bits.

Top module: `casc_bin_counter`

## Requirements
- R1: State changes only on the rising edge of `clk`. A change on any input between edges leaves `count` unchanged until the next rising edge.
- R2: When `clr_n` is 0 at a rising edge, `count` becomes 0, whatever `load_n`, `din`, `en_par` and `en_trk` are.
- R3: When `clr_n` is 1 and `load_n` is 0 at a rising edge, `count` takes `din`, whatever `en_par` and `en_trk` are.
- R4: When `clr_n` and `load_n` are both 1 and `en_par` and `en_trk` are both 1 at a rising edge, `count` increments by one.
- R5: When `clr_n` and `load_n` are both 1 and either enable is 0 at a rising edge, `count` holds its value.
- R6: The count runs in natural binary order and wraps from all ones (15 for 4 bits) to 0.
- R7: `tc` is 1 exactly when `en_trk` is 1 and `count` is all ones. `en_par` has no effect on `tc`.
- R8: `tc` is combinational, with no register delay. After a load of all ones with `en_trk` high, `tc` is 1 in the same cycle. After a load of any other value, `tc` is 0.
- R9: When stages are chained, with each stage's `tc` driving the next stage's `en_trk` and the parallel enables driven in common, the chain counts as one wide binary counter. An upper stage increments on the same edge that the stage below wraps.
- R10: Driving `clr_n` from an external decode of count 9 makes a stage count 0 to 9 and return to 0 on the edge after 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| din | input | W | Preset value taken on a load |
| en_par | input | 1 | Parallel count enable, active high |
| en_trk | input | 1 | Trickle count enable, also gates `tc` |
| count | output | W | Current count |
| tc | output | 1 | Terminal-count flag |

## Verification
Three stages are chained into a 12-bit counter and compared each cycle against an arithmetic reference, with clear and load dropped in at arbitrary points. If the clear did not override the load, the counter would take `din` when it should go to 0. If a load obeyed the enables, presets would be lost whenever counting was disabled. A registered terminal-count flag would make the upper digits lag by one edge at every lower wrap, which the 12-bit comparison exposes at each carry. The bench also holds the parallel enable low at all ones to confirm `tc` ignores it, loads all ones to see `tc` rise at once, and runs a decode-to-9 stage to confirm the decade sequence.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
    // Operation chosen at an edge, listed lowest to highest priority.
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } cbc_op_e;
endpackage

// File: rtl/cbc_op_sel.sv
module cbc_op_sel
    import cbc_pkg::*;
(
    input  logic    clr_n,
    input  logic    load_n,
    input  logic    en_par,
    input  logic    en_trk,
    output cbc_op_e op
);
    always_comb begin
        if (!clr_n)                op = OP_CLEAR;
        else if (!load_n)          op = OP_LOAD;
        else if (en_par && en_trk) op = OP_COUNT;
        else                       op = OP_HOLD;
    end
endmodule

// File: rtl/cbc_incr.sv
module cbc_incr #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    output logic [W-1:0] y
);
    // Look-ahead form: each bit toggles when all bits below it are ones.
    logic [W-1:0] carry;
    assign carry[0] = 1'b1;
    genvar i;
    generate
        for (i = 1; i < W; i++) begin : g_carry
            assign carry[i] = &a[i-1:0];
        end
    endgenerate
    assign y = a ^ carry;
endmodule

// File: rtl/cbc_tc_dec.sv
module cbc_tc_dec #(
    parameter int W = 4
) (
    input  logic [W-1:0] cnt,
    input  logic         en_trk,
    output logic         tc
);
    assign tc = en_trk & (&cnt);
endmodule

// File: rtl/casc_bin_counter.sv
module casc_bin_counter
    import cbc_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic         load_n,
    input  logic [W-1:0] din,
    input  logic         en_par,
    input  logic         en_trk,
    output logic [W-1:0] count,
    output logic         tc
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } cbc_state_t;

    cbc_state_t st_d, st_q;
    cbc_op_e    op;
    logic [W-1:0] inc;

    cbc_op_sel u_sel (
        .clr_n (clr_n),
        .load_n(load_n),
        .en_par(en_par),
        .en_trk(en_trk),
        .op    (op)
    );

    cbc_incr #(.W(W)) u_inc (
        .a(st_q.cnt),
        .y(inc)
    );

    always_comb begin
        st_d = st_q;
        unique case (op)
            OP_CLEAR: st_d.cnt = '0;
            OP_LOAD:  st_d.cnt = din;
            OP_COUNT: st_d.cnt = inc;
            default:  st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign count = st_q.cnt;

    cbc_tc_dec #(.W(W)) u_tc (
        .cnt   (st_q.cnt),
        .en_trk(en_trk),
        .tc    (tc)
    );
endmodule

// File: rtl/cbc_checker.sv
module cbc_checker #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         clr_n,
    input logic         load_n,
    input logic [W-1:0] din,
    input logic         en_par,
    input logic         en_trk,
    input logic [W-1:0] count,
    input logic         tc
);
    // Armed once a clear has been seen, so the count is known.
    logic armed_q = 1'b0;
    always_ff @(posedge clk) begin
        if (!clr_n) armed_q <= 1'b1;
    end

    a_r2_clear_wins: assert property (@(posedge clk) disable iff (!armed_q)
        !clr_n |=> count == '0);

    a_r3_load_takes_din: assert property (@(posedge clk) disable iff (!armed_q)
        (clr_n && !load_n) |=> count == $past(din));

    a_r4_r6_increment: assert property (@(posedge clk) disable iff (!armed_q)
        (clr_n && load_n && en_par && en_trk) |=> count == W'($past(count) + 1'b1));

    a_r5_hold: assert property (@(posedge clk) disable iff (!armed_q)
        (clr_n && load_n && !(en_par && en_trk)) |=> $stable(count));

    a_r7_tc_needs_trk: assert property (@(posedge clk) disable iff (!armed_q)
        tc |-> (en_trk && (&count)));

    a_r7_tc_at_top: assert property (@(posedge clk) disable iff (!armed_q)
        (en_trk && (&count)) |-> tc);
endmodule

bind casc_bin_counter cbc_checker #(.W(W)) u_chk (
    .clk   (clk),
    .clr_n (clr_n),
    .load_n(load_n),
    .din   (din),
    .en_par(en_par),
    .en_trk(en_trk),
    .count (count),
    .tc    (tc)
);

// File: tb/sim_casc_bin_counter.sv
module sim_casc_bin_counter;
    localparam int PERIOD = 10;
    localparam int W = 4;
    localparam int N = 3;
    localparam int CW = W * N;

    logic clk = 1'b0;
    always #(PERIOD / 2) clk = ~clk;

    logic          clr_n = 1'b0, load_n = 1'b1, par0 = 1'b0, trk0 = 1'b0;
    logic [CW-1:0] din = '0;
    logic [CW-1:0] cnt;
    logic [N-1:0]  tcs;

    casc_bin_counter #(.W(W)) u0 (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din[3:0]),
        .en_par(par0), .en_trk(trk0), .count(cnt[3:0]), .tc(tcs[0]));
    casc_bin_counter #(.W(W)) u_s1 (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din[7:4]),
        .en_par(par0), .en_trk(tcs[0]), .count(cnt[7:4]), .tc(tcs[1]));
    casc_bin_counter #(.W(W)) u_s2 (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din[11:8]),
        .en_par(par0), .en_trk(tcs[1]), .count(cnt[11:8]), .tc(tcs[2]));

    // Decade stage: clear driven from a decode of count 9.
    logic         m_ext_n = 1'b0;
    logic [W-1:0] m_cnt;
    logic         m_tc;
    logic         m_clr_n;
    assign m_clr_n = m_ext_n & ~(m_cnt == 4'd9);
    casc_bin_counter #(.W(W)) u1 (
        .clk(clk), .clr_n(m_clr_n), .load_n(1'b1), .din(4'd0),
        .en_par(1'b1), .en_trk(1'b1), .count(m_cnt), .tc(m_tc));

    int runs = 0, fails = 0;
    logic [CW-1:0] ref_q = '0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
        runs++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input logic c, input logic l, input logic p, input logic t, input logic [CW-1:0] d);
        logic [CW-1:0] nxt;
        @(negedge clk);
        clr_n = c; load_n = l; par0 = p; trk0 = t; din = d;
        #1;
        chk(cnt == ref_q, "R1", cnt, ref_q);
        chk(tcs[0] == (t && ref_q[3:0] == 4'hF), "R7", {11'd0, tcs[0]}, {11'd0, t && ref_q[3:0] == 4'hF});
        if (!c)          nxt = '0;
        else if (!l)     nxt = d;
        else if (p && t) nxt = ref_q + 1'b1;
        else             nxt = ref_q;
        @(posedge clk);
        #1;
        ref_q = nxt;
        chk(cnt == ref_q, "R9", cnt, ref_q);
        chk(tcs[2] == (t && ref_q == '1), "R8", {11'd0, tcs[2]}, {11'd0, t && ref_q == '1});
    endtask

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", runs, fails);
            $finish;
        end
    end

    initial begin
        // R2: clear with load and enables active still gives 0.
        tick(1'b0, 1'b0, 1'b1, 1'b1, 12'hABC);
        chk(cnt == '0, "R2", cnt, '0);
        // R4/R6/R9: free-running count over full 12-bit range plus wrap.
        for (int i = 0; i < 4100; i++) tick(1'b1, 1'b1, 1'b1, 1'b1, 12'h000);
        chk(cnt == 12'd4, "R6", cnt, 12'd4);
        // R5: each enable low holds.
        tick(1'b1, 1'b1, 1'b0, 1'b1, 12'h000);
        chk(cnt == 12'd4, "R5", cnt, 12'd4);
        tick(1'b1, 1'b1, 1'b1, 1'b0, 12'h000);
        chk(cnt == 12'd4, "R5", cnt, 12'd4);
        // R3: load with enables low.
        tick(1'b1, 1'b0, 1'b0, 1'b0, 12'h5A3);
        chk(cnt == 12'h5A3, "R3", cnt, 12'h5A3);
        // R8: load all ones gives tc at once, other value clears it.
        tick(1'b1, 1'b0, 1'b0, 1'b1, 12'hFFF);
        chk(tcs[2] == 1'b1, "R8", {11'd0, tcs[2]}, 12'd1);
        // R7: parallel enable low does not gate tc.
        chk(tcs[0] == 1'b1, "R7", {11'd0, tcs[0]}, 12'd1);
        tick(1'b1, 1'b0, 1'b1, 1'b1, 12'hFFE);
        chk(tcs[2] == 1'b0, "R8", {11'd0, tcs[2]}, 12'd0);
        // Mixed stimulus with clear and load mid-count.
        for (int i = 0; i < 3000; i++) begin
            int r = $urandom % 64;
            tick(r != 0, r != 1, (r % 5) != 2, (r % 7) != 3, 12'($urandom));
        end
        // R10: decade stage.
        @(negedge clk); m_ext_n = 1'b0;
        @(negedge clk); m_ext_n = 1'b1;
        for (int i = 0; i < 30; i++) begin
            chk(m_cnt == 4'(i % 10), "R10", {8'd0, m_cnt}, 12'(i % 10));
            @(negedge clk);
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end
endmodule